// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of address windows that software programs through a small 32-bit register port. Each incoming 48-bit physical address is compared against every enabled window. The block returns a hit flag, the 4-bit target identifier of the winning window, and an access-denied flag. The result is registered and appears one cycle after the lookup.

Window 0 covers configuration space. It is always enabled and always spans 16 MB from its programmed base. Every other window has a base and an inclusive last megabyte, both in 1 MB units, and can be switched on or off. Each window also has secure-only flags. A non-secure read or write that lands in a protected window is flagged as denied.

Each window has two DMA steering bits. These are only stored and read back.

Top module: `addrwin_decoder`

## Requirements
- R1: After reset, windows 1 and up are disabled and every field of them reads zero. Window 0 is enabled with target 0 and base 0, so address 0 hits target 0.
- R2: Register layout. Window w's registers start at byte offset w*0x20.
  - +0x0 control: bit 0 enable, bits [11:8] target.
  - +0x4 security: bits [3:0].
  - +0x8 base: bits [31:4] hold address bits [47:20]; bits [3:0] always read 0.
  - +0xC last: same layout as base.
  - +0x10 DMA steering: bits [1:0].
  - All other bits and offsets read 0.
- R3: A window w≥1 matches when it is enabled and base ≤ addr[47:20] ≤ last. A disabled window never matches.
- R4: Window 0 matches base ≤ addr[47:20] < base+16, a 16 MB span. Its last register is stored but has no effect on matching.
- R5: Writing 0 to window 0's enable bit has no effect; it reads back as 1 and keeps matching.
- R6: When several windows match, the lowest-numbered one supplies the target.
- R7: The result for a lookup presented in cycle N appears in cycle N+1. res_valid is high exactly in the cycles after lk_valid was high, and res_hit is low whenever res_valid is low.
- R8: A miss returns res_hit=0, res_target=0 and res_denied=0.
- R9: Security bits and denial.
  - A non-secure write that hits a window with security bit 2 set is denied.
  - A non-secure read that hits a window with security bit 3 set is denied.
  - A secure access is never denied.
  - Security bits 0 and 1 are stored but do not affect denial.
  - A denied access still reports res_hit=1 and its target.
- R10: The DMA steering bits are stored and read back, and have no effect on lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address (read and write) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Physical address to decode |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_secure | input | 1 | 1 = secure access |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled window matched |
| res_target | output | 4 | Target identifier of the winning window |
| res_denied | output | 1 | Non-secure access to a protected window |

## Verification
A corrupted window field shows up in two places. It changes the read-back value at that window's offset in the same cycle. It also changes the target or hit of the next lookup whose address falls at the window's edges.

The stimulus probes both sides of every boundary: one unit below the base, the base itself, the last megabyte, and one unit past it. An off-by-one comparison therefore gives a wrong hit one cycle after the lookup. Overlapping windows and a disabled window that would otherwise win expose a wrong priority choice. Toggling individual security bits shows whether a wrong bit is being decoded for denial.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
   // word index inside a window's 0x20-byte block (byte offset >> 2)
   typedef enum logic [2:0] {
      WREG_CTRL = 3'd0,
      WREG_SEC  = 3'd1,
      WREG_BASE = 3'd2,
      WREG_LAST = 3'd3,
      WREG_DMA  = 3'd4
   } wreg_e;

   localparam int unsigned CTRL_TGT_LSB = 8;
   localparam int unsigned UNIT_LSB     = 4;
   localparam int unsigned SEC_W        = 4;
   localparam int unsigned SEC_DWR      = 2;
   localparam int unsigned SEC_DRD      = 3;
   localparam int unsigned DMA_W        = 2;
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
   import addrwin_pkg::*;
#(
   parameter int unsigned NUM_WIN = 16,
   parameter int unsigned UNIT_W  = 28,
   parameter int unsigned TGT_W   = 4,
   parameter int unsigned REG_AW  = 9
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [REG_AW-1:0]                   addr,
   input  logic [31:0]                         wdata,
   output logic [31:0]                         rdata,
   output logic [NUM_WIN-1:0]                  win_en,
   output logic [NUM_WIN-1:0][TGT_W-1:0]       win_tgt,
   output logic [NUM_WIN-1:0][SEC_W-1:0]       win_sec,
   output logic [NUM_WIN-1:0][UNIT_W-1:0]      win_base,
   output logic [NUM_WIN-1:0][UNIT_W-1:0]      win_last
);
   localparam int unsigned WIDX_W = REG_AW - 5;

   logic [NUM_WIN-1:0][DMA_W-1:0] win_dma;
   logic [WIDX_W-1:0]             idx;
   wreg_e                         wsel;

   assign idx  = addr[REG_AW-1:5];
   assign wsel = wreg_e'(addr[4:2]);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic hit_w;
      assign hit_w = wr_en && (idx == WIDX_W'(w)) && (addr[1:0] == 2'b00);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_tgt[w]  <= '0;
            win_sec[w]  <= '0;
            win_base[w] <= '0;
            win_last[w] <= '0;
            win_dma[w]  <= '0;
         end else if (hit_w) begin
            case (wsel)
               WREG_CTRL: win_tgt[w]  <= wdata[CTRL_TGT_LSB +: TGT_W];
               WREG_SEC:  win_sec[w]  <= wdata[SEC_W-1:0];
               WREG_BASE: win_base[w] <= wdata[UNIT_LSB +: UNIT_W];
               WREG_LAST: win_last[w] <= wdata[UNIT_LSB +: UNIT_W];
               WREG_DMA:  win_dma[w]  <= wdata[DMA_W-1:0];
               default: ;
            endcase
         end
      end

      if (w == 0) begin : g_cfg_win
         assign win_en[w] = 1'b1;
      end else begin : g_prog_win
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           win_en[w] <= 1'b0;
            else if (hit_w && wsel == WREG_CTRL)  win_en[w] <= wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (int'(idx) < NUM_WIN && addr[1:0] == 2'b00) begin
         case (wsel)
            WREG_CTRL: begin
               rdata[0]                     = win_en[idx];
               rdata[CTRL_TGT_LSB +: TGT_W] = win_tgt[idx];
            end
            WREG_SEC:  rdata[SEC_W-1:0]        = win_sec[idx];
            WREG_BASE: rdata[UNIT_LSB +: UNIT_W] = win_base[idx];
            WREG_LAST: rdata[UNIT_LSB +: UNIT_W] = win_last[idx];
            WREG_DMA:  rdata[DMA_W-1:0]        = win_dma[idx];
            default:   rdata = '0;
         endcase
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match #(
   parameter int unsigned NUM_WIN   = 16,
   parameter int unsigned UNIT_W    = 28,
   parameter int unsigned CFG_UNITS = 16
) (
   input  logic [UNIT_W-1:0]                 unit,
   input  logic [NUM_WIN-1:0]                win_en,
   input  logic [NUM_WIN-1:0][UNIT_W-1:0]    win_base,
   input  logic [NUM_WIN-1:0][UNIT_W-1:0]    win_last,
   output logic [NUM_WIN-1:0]                hit_vec
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      if (w == 0) begin : g_fixed_span
         logic [UNIT_W:0] lim;
         assign lim        = {1'b0, win_base[w]} + (UNIT_W+1)'(CFG_UNITS);
         assign hit_vec[w] = win_en[w] && (unit >= win_base[w]) &&
                             ({1'b0, unit} < lim);
         logic unused_last;
         assign unused_last = ^win_last[w];
      end else begin : g_bounded
         assign hit_vec[w] = win_en[w] && (unit >= win_base[w]) &&
                             (unit <= win_last[w]);
      end
   end
endmodule

// File: rtl/addrwin_pick.sv
module addrwin_pick
   import addrwin_pkg::*;
#(
   parameter int unsigned NUM_WIN = 16,
   parameter int unsigned TGT_W   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              lk_valid,
   input  logic                              lk_write,
   input  logic                              lk_secure,
   input  logic [NUM_WIN-1:0]                hit_vec,
   input  logic [NUM_WIN-1:0][TGT_W-1:0]     win_tgt,
   input  logic [NUM_WIN-1:0][SEC_W-1:0]     win_sec,
   output logic                              res_valid,
   output logic                              res_hit,
   output logic [TGT_W-1:0]                  res_target,
   output logic                              res_denied
);
   logic             any;
   logic [TGT_W-1:0] sel_tgt;
   logic [SEC_W-1:0] sel_sec;
   logic             deny;

   always_comb begin
      any     = 1'b0;
      sel_tgt = '0;
      sel_sec = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any     = 1'b1;
            sel_tgt = win_tgt[i];
            sel_sec = win_sec[i];
         end
      end
   end

   assign deny = any && !lk_secure &&
                 (lk_write ? sel_sec[SEC_DWR] : sel_sec[SEC_DRD]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_target <= '0;
         res_denied <= 1'b0;
      end else begin
         res_valid  <= lk_valid;
         res_hit    <= lk_valid && any;
         res_target <= (lk_valid && any) ? sel_tgt : '0;
         res_denied <= lk_valid && deny;
      end
   end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
   import addrwin_pkg::*;
#(
   parameter int unsigned NUM_WIN     = 16,
   parameter int unsigned ADDR_W      = 48,
   parameter int unsigned GRAN_SH     = 20,
   parameter int unsigned TGT_W       = 4,
   parameter int unsigned CFG_SPAN_SH = 24,
   localparam int unsigned UNIT_W     = ADDR_W - GRAN_SH,
   localparam int unsigned WIDX_W     = $clog2(NUM_WIN),
   localparam int unsigned REG_AW     = WIDX_W + 5,
   localparam int unsigned CFG_UNITS  = 1 << (CFG_SPAN_SH - GRAN_SH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_write,
   input  logic              lk_secure,
   output logic              res_valid,
   output logic              res_hit,
   output logic [TGT_W-1:0]  res_target,
   output logic              res_denied
);
   if (NUM_WIN < 2) begin : g_bad_num
      $error("addrwin_decoder: NUM_WIN must be at least 2");
   end
   if (UNIT_W > 28 || UNIT_W < 1) begin : g_bad_unit
      $error("addrwin_decoder: ADDR_W-GRAN_SH must be 1..28");
   end
   if (TGT_W < 1 || TGT_W > 8) begin : g_bad_tgt
      $error("addrwin_decoder: TGT_W must be 1..8");
   end
   if (CFG_SPAN_SH < GRAN_SH) begin : g_bad_span
      $error("addrwin_decoder: CFG_SPAN_SH below granularity");
   end

   logic [NUM_WIN-1:0]               win_en;
   logic [NUM_WIN-1:0][TGT_W-1:0]    win_tgt;
   logic [NUM_WIN-1:0][SEC_W-1:0]    win_sec;
   logic [NUM_WIN-1:0][UNIT_W-1:0]   win_base;
   logic [NUM_WIN-1:0][UNIT_W-1:0]   win_last;
   logic [NUM_WIN-1:0]               hit_vec;

   addrwin_regs #(
      .NUM_WIN(NUM_WIN), .UNIT_W(UNIT_W), .TGT_W(TGT_W), .REG_AW(REG_AW)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .win_en(win_en),
      .win_tgt(win_tgt), .win_sec(win_sec), .win_base(win_base),
      .win_last(win_last)
   );

   addrwin_match #(
      .NUM_WIN(NUM_WIN), .UNIT_W(UNIT_W), .CFG_UNITS(CFG_UNITS)
   ) i_match (
      .unit(lk_addr[ADDR_W-1:GRAN_SH]), .win_en(win_en),
      .win_base(win_base), .win_last(win_last), .hit_vec(hit_vec)
   );

   addrwin_pick #(
      .NUM_WIN(NUM_WIN), .TGT_W(TGT_W)
   ) i_pick (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
      .lk_secure(lk_secure), .hit_vec(hit_vec), .win_tgt(win_tgt),
      .win_sec(win_sec), .res_valid(res_valid), .res_hit(res_hit),
      .res_target(res_target), .res_denied(res_denied)
   );

   logic unused_low;
   assign unused_low = ^lk_addr[GRAN_SH-1:0];
endmodule

// File: rtl/addrwin_checker.sv
module addrwin_checker #(
   parameter int unsigned REG_AW = 9,
   parameter int unsigned TGT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] cfg_addr,
   input logic [31:0]       cfg_rdata,
   input logic              lk_valid,
   input logic              lk_secure,
   input logic              res_valid,
   input logic              res_hit,
   input logic [TGT_W-1:0]  res_target,
   input logic              res_denied
);
   p_lat_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   p_lat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);
   p_idle_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !res_hit);
   p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_target == '0 && !res_denied));
   p_deny_nonsec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_denied |-> (res_hit && !$past(lk_secure)));
   p_cfg_win_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == '0) |-> cfg_rdata[0]);
   p_base_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr[4:0] == 5'h08) |-> (cfg_rdata[3:0] == 4'h0));
endmodule

bind addrwin_decoder addrwin_checker #(.REG_AW(REG_AW), .TGT_W(TGT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
   .lk_valid(lk_valid), .lk_secure(lk_secure), .res_valid(res_valid),
   .res_hit(res_hit), .res_target(res_target), .res_denied(res_denied)
);

// File: tb/test_addrwin_decoder.sv
module test_addrwin_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [8:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_valid = 1'b0;
   logic [47:0] lk_addr = '0;
   logic        lk_write = 1'b0;
   logic        lk_secure = 1'b0;
   logic        res_valid, res_hit, res_denied;
   logic [3:0]  res_target;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic       hit;
      logic [3:0] tgt;
      logic       den;
      string      req;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   addrwin_decoder i_addrwin_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .lk_write(lk_write), .lk_secure(lk_secure),
      .res_valid(res_valid), .res_hit(res_hit), .res_target(res_target),
      .res_denied(res_denied)
   );

   function automatic logic [8:0] ra(input int w, input int ofs);
      return 9'(w * 32 + ofs);
   endfunction

   task automatic wr(input int w, input int ofs, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = ra(w, ofs); cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int w, input int ofs, input logic [31:0] e,
                         input string req);
      @(negedge clk);
      cfg_addr = ra(w, ofs);
      #1;
      total++;
      if (cfg_rdata !== e) begin
         bad++;
         $display("FAIL %s: reg w%0d+0x%0h actual=%h expected=%h",
                  req, w, ofs, cfg_rdata, e);
      end
   endtask

   task automatic look(input logic [47:0] a, input logic wrt, input logic sec,
                       input logic eh, input logic [3:0] et, input logic ed,
                       input string req);
      exp_t e;
      @(negedge clk);
      e.hit = eh; e.tgt = et; e.den = ed; e.req = req;
      sb.push_back(e);
      lk_valid = 1'b1; lk_addr = a; lk_write = wrt; lk_secure = sec;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R7: unexpected result hit=%b expected none", res_hit);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (res_hit !== e.hit || res_target !== e.tgt || res_denied !== e.den) begin
               bad++;
               $display("FAIL %s: actual hit=%b tgt=%0d den=%b expected hit=%b tgt=%0d den=%b",
                        e.req, res_hit, res_target, res_denied, e.hit, e.tgt, e.den);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk(0, 'h0, 32'h1, "R1");
      rd_chk(1, 'h0, 32'h0, "R1");
      rd_chk(15, 'h8, 32'h0, "R1");
      look(48'h0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, "R1");
      look(48'h1000_0000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R1");
      // R4 fixed 16 MB span of window 0
      look(48'h00FF_FFFF, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, "R4");
      look(48'h0100_0000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R8");
      // R5 window 0 enable cannot be cleared
      wr(0, 'h0, 32'h0000_0300);
      rd_chk(0, 'h0, 32'h0000_0301, "R5");
      look(48'h0, 1'b1, 1'b0, 1'b1, 4'd3, 1'b0, "R5");
      // R4 move window 0, last register ignored
      wr(0, 'h8, 32'h0080_0000);
      wr(0, 'hC, 32'hFFFF_FFF0);
      rd_chk(0, 'hC, 32'hFFFF_FFF0, "R2");
      look(48'h80_0000_0000, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, "R4");
      look(48'h80_00FF_FFFF, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, "R4");
      look(48'h80_0100_0000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R4");
      look(48'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R4");
      // R2/R3 window 2 bounds
      wr(2, 'h8, 32'h0000_100F);
      wr(2, 'hC, 32'h0000_1FF0);
      rd_chk(2, 'h8, 32'h0000_1000, "R2");
      rd_chk(2, 'h14, 32'h0, "R2");
      look(48'h1000_0000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R3");
      wr(2, 'h0, 32'h0000_0501);
      rd_chk(2, 'h0, 32'h0000_0501, "R2");
      look(48'h0FFF_FFFF, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R3");
      look(48'h1000_0000, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0, "R3");
      look(48'h1FFF_FFFF, 1'b1, 1'b1, 1'b1, 4'd5, 1'b0, "R3");
      look(48'h2000_0000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R3");
      // R6 overlap with window 5
      wr(5, 'h8, 32'h0000_1800);
      wr(5, 'hC, 32'h0000_2FF0);
      wr(5, 'h0, 32'h0000_0901);
      look(48'h1800_0000, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0, "R6");
      look(48'h2500_0000, 1'b0, 1'b0, 1'b1, 4'd9, 1'b0, "R6");
      // highest window, single-megabyte span
      wr(15, 'h8, 32'h0000_4000);
      wr(15, 'hC, 32'h0000_4000);
      wr(15, 'h0, 32'h0000_0F01);
      look(48'h4000_0000, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0, "R3");
      look(48'h400F_FFFF, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0, "R3");
      look(48'h4010_0000, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R3");
      // R9 security
      wr(2, 'h4, 32'h0000_0004);
      look(48'h1000_0000, 1'b1, 1'b0, 1'b1, 4'd5, 1'b1, "R9");
      look(48'h1000_0000, 1'b0, 1'b0, 1'b1, 4'd5, 1'b0, "R9");
      look(48'h1000_0000, 1'b1, 1'b1, 1'b1, 4'd5, 1'b0, "R9");
      wr(2, 'h4, 32'hFFFF_FFFB);
      rd_chk(2, 'h4, 32'h0000_000B, "R9");
      look(48'h1000_0000, 1'b1, 1'b0, 1'b1, 4'd5, 1'b0, "R9");
      look(48'h1000_0000, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1, "R9");
      look(48'h1000_0000, 1'b0, 1'b1, 1'b1, 4'd5, 1'b0, "R9");
      // R10 DMA bits
      wr(2, 'h10, 32'hFFFF_FFFF);
      rd_chk(2, 'h10, 32'h0000_0003, "R10");
      look(48'h1000_0000, 1'b0, 1'b1, 1'b1, 4'd5, 1'b0, "R10");
      wr(1, 'h10, 32'h0000_0002);
      rd_chk(1, 'h10, 32'h0000_0002, "R10");
      look(48'h0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, "R10");
      // R3 disabling window 2 lets window 5 win
      wr(2, 'h0, 32'h0000_0500);
      rd_chk(2, 'h0, 32'h0000_0500, "R3");
      look(48'h1800_0000, 1'b0, 1'b0, 1'b1, 4'd9, 1'b0, "R3");
      look(48'h1000_0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, "R8");
      repeat (3) @(negedge clk);
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R7: pending results actual=%0d expected=0", sb.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule